// File: doc/BRIEF.md
# Timed Toggle Event Player

This block turns a queue of timed toggle events into edges on twelve output pins. A producer elsewhere on the chip fills a ring of event entries. Each entry holds a 12-bit flip mask and an 8-bit delay code. The player reads the entry at its read pointer and XORs the mask into its output register. It then counts out the encoded delay before it takes the next entry. Because every output edge comes from a mask, many free-running square waves can be produced from one shared timer instead of one counter per channel.

The ring is outside the block. The player drives a byte-addressed read pointer and sees the entry at that address on its mask and delay inputs in the same cycle. It also watches the producer's write pointer; the ring is empty when the two pointers are equal. After reset the player stays idle for a fixed holdoff so that the producer can get ahead. If an entry is due while the ring is empty, the player freezes its outputs, sets a sticky underrun flag, and plays the entry as soon as one arrives.

Top module: `tone_event_player`

## Requirements
- R1: While reset is asserted and immediately after it is released, `tone_out` is 0, `rd_ptr` is 0 and `underrun` is 0.
- R2: The first entry is applied at exactly the HOLDOFF-th rising clock edge after reset is released (HOLDOFF defaults to 2048). Before that edge, `tone_out` and `rd_ptr` do not change.
- R3: Applying an entry sets `tone_out` to `tone_out ^ ent_mask`. Mask bit k flips pin k: bits 7:0 drive the low group of eight pins and bits 11:8 drive the upper four pins. Pins change only when an entry is applied.
- R4: After an entry with delay code d is applied, the next entry is applied exactly (d+1)*TICK clocks later, with TICK defaulting to 20. So d=0 gives 20 clocks, d=2 gives 60 clocks and d=255 gives 5120 clocks.
- R5: `rd_ptr` is a byte address whose two low bits are always 0. It advances by 4 for each applied entry and wraps from 252 to 0.
- R6: If `rd_ptr == wr_ptr` when an entry is due, `underrun` is set, and `tone_out` and `rd_ptr` hold. Once set, `underrun` stays 1 until reset.
- R7: A due entry is applied at the first clock edge at which `wr_ptr != rd_ptr`. This includes an entry whose write pointer advances in the very cycle it becomes due; in that case `underrun` is not raised.
- R8: After a late entry is applied, the spacing to the next entry is measured from the late entry's own application edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr | input | 8 | Producer's byte write pointer into the ring |
| rd_ptr | output | 8 | Byte read pointer; selects the entry on `ent_mask`/`ent_delay` |
| ent_mask | input | 12 | Flip mask of the entry at `rd_ptr` |
| ent_delay | input | 8 | Delay code of the entry at `rd_ptr` |
| tone_out | output | 12 | Output pins |
| underrun | output | 1 | Sticky flag: an entry was due while the ring was empty |

## Verification
Two functions can land on the same edge: the delay expiring, and the producer's write pointer moving off the read pointer. The bench provokes this by holding the ring empty through the holdoff. It then advances `wr_ptr` in the half cycle just before the holdoff edge. It judges that the mask appears after exactly one more edge, with `underrun` still 0. A second case lets the ring run dry so that the flag rises, supplies data late, and checks that the entry plays on the next edge and that the following spacing counts from that edge.

// File: rtl/tone_event_player.sv
module tone_event_player #(
  parameter int TICK    = 20,
  parameter int HOLDOFF = 2048,
  parameter int NOUT    = 12,
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int STEP    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   wr_ptr,
  output logic [AW-1:0]   rd_ptr,
  input  logic [NOUT-1:0] ent_mask,
  input  logic [DW-1:0]   ent_delay,
  output logic [NOUT-1:0] tone_out,
  output logic            underrun
);
  localparam int MAXV = ((1 << DW) * TICK > HOLDOFF) ? (1 << DW) * TICK : HOLDOFF;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] wait_q;
  logic [CW-1:0] reload;
  logic          due, empty, fire;

  assign due    = (wait_q == '0);
  assign empty  = (rd_ptr == wr_ptr);
  assign fire   = due && !empty;
  assign reload = CW'((32'(ent_delay) + 32'd1) * 32'(TICK) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q   <= CW'(HOLDOFF - 1);
      rd_ptr   <= '0;
      tone_out <= '0;
      underrun <= 1'b0;
    end else if (fire) begin
      tone_out <= tone_out ^ ent_mask;
      rd_ptr   <= rd_ptr + AW'(STEP);
      wait_q   <= reload;
    end else if (due) begin
      underrun <= 1'b1;
    end else begin
      wait_q   <= wait_q - 1'b1;
    end
  end
endmodule

// File: rtl/tone_event_player_chk.sv
module tone_event_player_chk #(
  parameter int HOLDOFF = 2048,
  parameter int NOUT    = 12,
  parameter int AW      = 8,
  parameter int STEP    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   wr_ptr,
  input logic [AW-1:0]   rd_ptr,
  input logic [NOUT-1:0] tone_out,
  input logic            underrun
);
  logic [31:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < 32'(HOLDOFF)) since_rst <= since_rst + 1;
  end

  // R2
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 32'(HOLDOFF)) |-> (rd_ptr == '0 && tone_out == '0));

  // R5
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr[1:0] == 2'b00);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == $past(rd_ptr) + AW'(STEP)));

  // R3
  toggle_with_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_out != $past(tone_out)) |-> (rd_ptr != $past(rd_ptr)));

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == wr_ptr) |=> ($stable(tone_out) && $stable(rd_ptr)));

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R6
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(rd_ptr == wr_ptr));
endmodule

bind tone_event_player tone_event_player_chk #(
  .HOLDOFF(HOLDOFF), .NOUT(NOUT), .AW(AW), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .tone_out(tone_out), .underrun(underrun)
);

// File: tb/tone_event_player_bench.sv
`timescale 1ns/1ps
module tone_event_player_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wr_ptr = '0;
  logic [7:0]  rd_ptr;
  logic [11:0] ent_mask;
  logic [7:0]  ent_delay;
  logic [11:0] tone_out;
  logic        underrun;

  logic [11:0] rmask [64];
  logic [7:0]  rdel  [64];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign ent_mask  = rmask[rd_ptr[7:2]];
  assign ent_delay = rdel[rd_ptr[7:2]];

  tone_event_player u_tone_event_player (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .ent_mask(ent_mask), .ent_delay(ent_delay),
    .tone_out(tone_out), .underrun(underrun)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_ptr = '0;
    for (int i = 0; i < 64; i++) begin rmask[i] = '0; rdel[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_change(string tag, int exp_gap, logic [11:0] exp_val);
    logic [11:0] prev = tone_out;
    int gap = 0;
    do begin @(negedge clk); gap++; end while (tone_out == prev && gap < 8000);
    chk({tag, " spacing"}, gap, exp_gap);
    chk({tag, " pins"}, tone_out, exp_val);
  endtask

  task automatic t_holdoff_and_spacing();
    do_reset();
    rmask[0] = 12'h001; rdel[0] = 8'd0;
    rmask[1] = 12'hF00; rdel[1] = 8'd2;
    rmask[2] = 12'h0FF; rdel[2] = 8'd255;
    rmask[3] = 12'hA5A; rdel[3] = 8'd0;
    rmask[4] = 12'h800; rdel[4] = 8'd0;
    wr_ptr = 8'd20;
    chk("R1 pins at reset", tone_out, 0);
    chk("R1 rd_ptr at reset", rd_ptr, 0);
    chk("R1 underrun at reset", underrun, 0);
    wait_change("R2 holdoff", 2048, 12'h001);
    chk("R5 rd_ptr step", rd_ptr, 4);
    wait_change("R4 delay 0", 20, 12'hF01);
    wait_change("R4 delay 2", 60, 12'hFFE);
    wait_change("R3 low group", 5120, 12'h5A4);
    wait_change("R3 high group", 20, 12'hDA4);
    chk("R5 rd_ptr after five", rd_ptr, 20);
    repeat (30) @(negedge clk);
    chk("R6 underrun on empty", underrun, 1);
    chk("R6 pins hold", tone_out, 12'hDA4);
    chk("R6 rd_ptr hold", rd_ptr, 20);
  endtask

  task automatic t_coincide_and_late();
    do_reset();
    rmask[0] = 12'h003; rdel[0] = 8'd0;
    rmask[1] = 12'h030; rdel[1] = 8'd1;
    repeat (2047) @(negedge clk);
    chk("R2 quiet before holdoff", tone_out, 0);
    wr_ptr = 8'd4;
    wait_change("R7 same-cycle arrival", 1, 12'h003);
    chk("R7 no underrun on same-cycle arrival", underrun, 0);
    repeat (25) @(negedge clk);
    chk("R6 underrun when dry", underrun, 1);
    chk("R6 pins frozen", tone_out, 12'h003);
    chk("R6 rd_ptr frozen", rd_ptr, 4);
    wr_ptr = 8'd8;
    @(negedge clk);
    chk("R7 late entry applied next edge", tone_out, 12'h033);
    chk("R7 rd_ptr after late entry", rd_ptr, 8);
    rmask[2] = 12'h300; rdel[2] = 8'd0;
    wr_ptr = 8'd12;
    wait_change("R8 spacing from late apply", 40, 12'h333);
    chk("R6 underrun sticky", underrun, 1);
  endtask

  task automatic t_wrap();
    logic [11:0] model = '0;
    do_reset();
    for (int k = 0; k < 63; k++) begin
      rmask[k] = 12'((k * 37 + 1) & 12'hFFF); rdel[k] = 8'd0;
    end
    wr_ptr = 8'd252;
    for (int k = 0; k < 60; k++) begin
      model = model ^ rmask[k];
      wait_change("R5 wrap run", (k == 0) ? 2048 : 20, model);
    end
    rmask[63] = 12'h123; rdel[63] = 8'd0;
    rmask[0]  = 12'h456; rdel[0]  = 8'd0;
    rmask[1]  = 12'h789; rdel[1]  = 8'd0;
    wr_ptr = 8'd8;
    for (int k = 60; k < 64; k++) begin
      model = model ^ rmask[k];
      wait_change("R4 wrap run", 20, model);
    end
    chk("R5 rd_ptr wraps to 0", rd_ptr, 0);
    model = model ^ 12'h456;
    wait_change("R5 first entry after wrap", 20, model);
    chk("R5 rd_ptr after wrap", rd_ptr, 4);
    chk("R6 no underrun while fed", underrun, 0);
  endtask

  initial begin
    t_holdoff_and_spacing();
    t_coincide_and_late();
    t_wrap();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule